// File: doc/BRIEF.md
# Operand Hazard Interlock and Forwarding Controller

This block guards the decode stage of a five-stage in-order integer pipeline against read-after-write hazards. Each cycle it looks at the instruction sitting in decode (its class, two source register numbers and a valid bit) and at the instructions in execute, memory and writeback (class, destination and valid bit). From the class codes it works out which sources the decode instruction reads and which older instructions write a register. It then compares register numbers and produces two kinds of result. The first is a hold request, which freezes fetch and decode and puts a bubble into execute. The second is a forwarding select for each of the two ALU operands.

The block is purely combinational, so every result belongs to the same cycle as its inputs. A parameter sets how much forwarding the surrounding datapath provides. In interlock mode there is no forwarding, and every hazard holds decode. In execute-only mode, ALU results can be forwarded from execute, and any other hazard holds. In full mode, results can be forwarded from all three older stages, and only a load in execute whose destination feeds decode causes a hold. The register file, ALU and memories belong to the surrounding pipeline.

Top module: `hz_ctrl`

## Requirements
- R1: Class codes are ALU=0, ALU-immediate=1, load=2, store=3, branch=4, jump-and-link=5, register-jump-and-link=6, no-operand=7. Source 1 counts as read for classes 0, 1, 2, 3, 4 and 6. Source 2 counts as read only for classes 0, 3 and 4.
- R2: Classes 0, 1, 2, 5 and 6 write their destination. Store, branch and no-operand instructions never cause a hold or a forward.
- R3: A destination of register 0 never matches, and neither does a stage whose valid bit is low.
- R4: When the decode valid bit is low, the hold output is low and both operand selects are 0.
- R5: The operand select encoding is 0 for the register file, 1 for the execute result, 2 for the memory-stage result and 3 for the writeback value. Each operand is resolved on its own, with execute taking priority over memory and memory over writeback.
- R6: In interlock mode (FWD_MODE=0), any match of a read source holds decode, and both selects always stay 0.
- R7: In execute-only mode (FWD_MODE=1), a match in execute with an ALU or ALU-immediate instruction forwards with select 1. A match in execute with a load or either jump-and-link form holds. Any match in memory or writeback holds.
- R8: In full mode (FWD_MODE=2, the default), an execute match forwards unless the execute instruction is a load. Memory and writeback matches always forward. The hold output is high only when a load in execute, with a nonzero destination, matches a read source.
- R9: For each operand, only the youngest matching stage decides the outcome. If that stage cannot forward, decode holds, even when an older stage could have supplied the value.
- R10: When a dependent instruction sits directly behind its producer and the pipeline advances on every cycle without a hold, decode is held for these numbers of cycles: 3 in interlock mode for any producer; 3 in execute-only mode for a load or jump-and-link producer and 0 for an ALU producer; 1 in full mode for a load producer and 0 for an ALU or jump-and-link producer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_vld | input | 1 | Decode instruction valid |
| dec_cls | input | 3 | Decode instruction class code |
| dec_src1 | input | REG_W | Decode source register 1 |
| dec_src2 | input | REG_W | Decode source register 2 |
| ex_vld | input | 1 | Execute instruction valid |
| ex_cls | input | 3 | Execute instruction class code |
| ex_dst | input | REG_W | Execute destination register |
| mem_vld | input | 1 | Memory-stage instruction valid |
| mem_cls | input | 3 | Memory-stage instruction class code |
| mem_dst | input | REG_W | Memory-stage destination register |
| wb_vld | input | 1 | Writeback instruction valid |
| wb_cls | input | 3 | Writeback instruction class code |
| wb_dst | input | REG_W | Writeback destination register |
| hold_front | output | 1 | Freeze fetch and decode, bubble into execute |
| opa_sel | output | 2 | Operand A source select |
| opb_sel | output | 2 | Operand B source select |

## Verification
No register lies between any input and any output, so the hold and both selects are due in the same cycle as the stage contents that cause them. The bench changes the inputs one time unit after a rising edge and reads the outputs two time units later, well before the next edge. Results for all three modes are compared on every cycle against a behavioural model. For the hold-duration checks, the bench shifts its own model pipeline one stage per cycle, driven by the hold output it sampled. It counts the cycles in which decode was held until the hold drops, and compares that count with the expected number.

// File: rtl/hz_pkg.sv
package hz_pkg;

    typedef enum logic [2:0] {
        OPC_ALU    = 3'd0,
        OPC_ALUI   = 3'd1,
        OPC_LOAD   = 3'd2,
        OPC_STORE  = 3'd3,
        OPC_BRANCH = 3'd4,
        OPC_JAL    = 3'd5,
        OPC_JALR   = 3'd6,
        OPC_NONE   = 3'd7
    } op_cls_e;

    typedef enum logic [1:0] {
        SEL_RF  = 2'd0,
        SEL_EX  = 2'd1,
        SEL_MEM = 2'd2,
        SEL_WB  = 2'd3
    } opnd_sel_e;

    localparam int MODE_INTERLOCK = 0;
    localparam int MODE_EXONLY    = 1;
    localparam int MODE_FULL      = 2;

    function automatic logic reads_src1(op_cls_e c);
        unique case (c)
            OPC_ALU, OPC_ALUI, OPC_LOAD, OPC_STORE, OPC_BRANCH, OPC_JALR: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic reads_src2(op_cls_e c);
        unique case (c)
            OPC_ALU, OPC_STORE, OPC_BRANCH: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic writes_reg(op_cls_e c);
        unique case (c)
            OPC_ALU, OPC_ALUI, OPC_LOAD, OPC_JAL, OPC_JALR: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/hz_stage_match.sv
module hz_stage_match
    import hz_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             stg_vld,
    input  logic [2:0]       stg_cls,
    input  logic [REG_W-1:0] stg_dst,
    input  logic [REG_W-1:0] src_a,
    input  logic [REG_W-1:0] src_b,
    input  logic             use_a,
    input  logic             use_b,
    output logic             hit_a,
    output logic             hit_b
);

    logic live;

    always_comb begin
        live  = stg_vld && writes_reg(op_cls_e'(stg_cls)) && (stg_dst != '0);
        hit_a = live && use_a && (stg_dst == src_a);
        hit_b = live && use_b && (stg_dst == src_b);
    end

endmodule

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick
    import hz_pkg::*;
#(
    parameter int NSTG = 3
) (
    input  logic [NSTG-1:0] hit,
    input  logic [NSTG-1:0] can_fwd,
    output logic [1:0]      sel,
    output logic            block
);

    always_comb begin
        sel   = SEL_RF;
        block = 1'b0;
        if (hit[0]) begin
            if (can_fwd[0]) sel = SEL_EX;
            else            block = 1'b1;
        end else if (hit[1]) begin
            if (can_fwd[1]) sel = SEL_MEM;
            else            block = 1'b1;
        end else if (hit[2]) begin
            if (can_fwd[2]) sel = SEL_WB;
            else            block = 1'b1;
        end
    end

endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl
    import hz_pkg::*;
#(
    parameter int REG_W    = 5,
    parameter int FWD_MODE = MODE_FULL
) (
    input  logic             dec_vld,
    input  logic [2:0]       dec_cls,
    input  logic [REG_W-1:0] dec_src1,
    input  logic [REG_W-1:0] dec_src2,
    input  logic             ex_vld,
    input  logic [2:0]       ex_cls,
    input  logic [REG_W-1:0] ex_dst,
    input  logic             mem_vld,
    input  logic [2:0]       mem_cls,
    input  logic [REG_W-1:0] mem_dst,
    input  logic             wb_vld,
    input  logic [2:0]       wb_cls,
    input  logic [REG_W-1:0] wb_dst,
    output logic             hold_front,
    output logic [1:0]       opa_sel,
    output logic [1:0]       opb_sel
);

    localparam int NSTG = 3;

    logic             use_a, use_b;
    logic             stg_vld [NSTG];
    logic [2:0]       stg_cls [NSTG];
    logic [REG_W-1:0] stg_dst [NSTG];
    logic [NSTG-1:0]  hit_a, hit_b, can_fwd;
    logic             blk_a, blk_b;

    assign use_a = dec_vld && reads_src1(op_cls_e'(dec_cls));
    assign use_b = dec_vld && reads_src2(op_cls_e'(dec_cls));

    assign stg_vld[0] = ex_vld;   assign stg_cls[0] = ex_cls;   assign stg_dst[0] = ex_dst;
    assign stg_vld[1] = mem_vld;  assign stg_cls[1] = mem_cls;  assign stg_dst[1] = mem_dst;
    assign stg_vld[2] = wb_vld;   assign stg_cls[2] = wb_cls;   assign stg_dst[2] = wb_dst;

    for (genvar g = 0; g < NSTG; g++) begin : g_stage
        hz_stage_match #(.REG_W(REG_W)) u_match (
            .stg_vld (stg_vld[g]),
            .stg_cls (stg_cls[g]),
            .stg_dst (stg_dst[g]),
            .src_a   (dec_src1),
            .src_b   (dec_src2),
            .use_a   (use_a),
            .use_b   (use_b),
            .hit_a   (hit_a[g]),
            .hit_b   (hit_b[g])
        );

        if (FWD_MODE == MODE_FULL && g == 0) begin : g_full_ex
            assign can_fwd[g] = (op_cls_e'(stg_cls[g]) != OPC_LOAD);
        end else if (FWD_MODE == MODE_FULL) begin : g_full_old
            assign can_fwd[g] = 1'b1;
        end else if (FWD_MODE == MODE_EXONLY && g == 0) begin : g_exonly_ex
            assign can_fwd[g] = (op_cls_e'(stg_cls[g]) == OPC_ALU) ||
                                (op_cls_e'(stg_cls[g]) == OPC_ALUI);
        end else begin : g_none
            assign can_fwd[g] = 1'b0;
        end
    end

    hz_fwd_pick #(.NSTG(NSTG)) u_pick_a (
        .hit (hit_a), .can_fwd (can_fwd), .sel (opa_sel), .block (blk_a)
    );

    hz_fwd_pick #(.NSTG(NSTG)) u_pick_b (
        .hit (hit_b), .can_fwd (can_fwd), .sel (opb_sel), .block (blk_b)
    );

    assign hold_front = blk_a || blk_b;

endmodule

// File: rtl/hz_ctrl_chk.sv
module hz_ctrl_chk
    import hz_pkg::*;
#(
    parameter int REG_W    = 5,
    parameter int FWD_MODE = MODE_FULL
) (
    input logic             dec_vld,
    input logic [2:0]       dec_cls,
    input logic [REG_W-1:0] dec_src1,
    input logic [REG_W-1:0] dec_src2,
    input logic             ex_vld,
    input logic [2:0]       ex_cls,
    input logic [REG_W-1:0] ex_dst,
    input logic             mem_vld,
    input logic [2:0]       mem_cls,
    input logic [REG_W-1:0] mem_dst,
    input logic             wb_vld,
    input logic [2:0]       wb_cls,
    input logic [REG_W-1:0] wb_dst,
    input logic             hold_front,
    input logic [1:0]       opa_sel,
    input logic [1:0]       opb_sel
);

    logic known;

    always_comb begin
        known = !$isunknown({dec_vld, dec_cls, dec_src1, dec_src2, ex_vld, ex_cls, ex_dst,
                             mem_vld, mem_cls, mem_dst, wb_vld, wb_cls, wb_dst,
                             hold_front, opa_sel, opb_sel});
        if (known) begin
            a_r4_idle_quiet: assert (dec_vld || (!hold_front && opa_sel == 2'd0 && opb_sel == 2'd0))
                else $error("R4 outputs active with decode invalid");
            a_r3_ex_fwd_real: assert (opa_sel != 2'd1 ||
                                      (ex_vld && ex_dst != '0 && ex_dst == dec_src1))
                else $error("R3 operand A forwarded from execute without a true match");
            a_r5_mem_only_on_ex_miss: assert (opb_sel != 2'd2 ||
                                              !(ex_vld && writes_reg(op_cls_e'(ex_cls)) &&
                                                ex_dst != '0 && ex_dst == dec_src2))
                else $error("R5 operand B took memory stage over an execute match");
            a_r6_interlock_no_fwd: assert (FWD_MODE != MODE_INTERLOCK ||
                                           (opa_sel == 2'd0 && opb_sel == 2'd0))
                else $error("R6 forwarding seen in interlock mode");
            a_r7_exonly_ex_source: assert (FWD_MODE != MODE_EXONLY ||
                                           (opa_sel[1] == 1'b0 && opb_sel[1] == 1'b0))
                else $error("R7 older-stage forward in execute-only mode");
            a_r8_full_hold_on_load: assert (FWD_MODE != MODE_FULL || !hold_front ||
                                            (ex_vld && op_cls_e'(ex_cls) == OPC_LOAD && ex_dst != '0))
                else $error("R8 hold without a load in execute");
        end
    end

endmodule

bind hz_ctrl hz_ctrl_chk #(.REG_W(REG_W), .FWD_MODE(FWD_MODE)) u_chk (
    .dec_vld (dec_vld), .dec_cls (dec_cls), .dec_src1 (dec_src1), .dec_src2 (dec_src2),
    .ex_vld (ex_vld), .ex_cls (ex_cls), .ex_dst (ex_dst),
    .mem_vld (mem_vld), .mem_cls (mem_cls), .mem_dst (mem_dst),
    .wb_vld (wb_vld), .wb_cls (wb_cls), .wb_dst (wb_dst),
    .hold_front (hold_front), .opa_sel (opa_sel), .opb_sel (opb_sel)
);

// File: tb/hz_ctrl_tb.sv
module hz_ctrl_tb;

    localparam int RW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          dv, ev, mv, wv;
    logic [2:0]    dc, ec, mc, wc;
    logic [RW-1:0] s1, s2, ed, md, wd;

    logic [2:0] hold_v;
    logic [1:0] sa_v [3];
    logic [1:0] sb_v [3];

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    hz_ctrl #(.REG_W(RW), .FWD_MODE(0)) u_dut_il (
        .dec_vld(dv), .dec_cls(dc), .dec_src1(s1), .dec_src2(s2),
        .ex_vld(ev), .ex_cls(ec), .ex_dst(ed), .mem_vld(mv), .mem_cls(mc), .mem_dst(md),
        .wb_vld(wv), .wb_cls(wc), .wb_dst(wd),
        .hold_front(hold_v[0]), .opa_sel(sa_v[0]), .opb_sel(sb_v[0]));

    hz_ctrl #(.REG_W(RW), .FWD_MODE(1)) u_dut_ex (
        .dec_vld(dv), .dec_cls(dc), .dec_src1(s1), .dec_src2(s2),
        .ex_vld(ev), .ex_cls(ec), .ex_dst(ed), .mem_vld(mv), .mem_cls(mc), .mem_dst(md),
        .wb_vld(wv), .wb_cls(wc), .wb_dst(wd),
        .hold_front(hold_v[1]), .opa_sel(sa_v[1]), .opb_sel(sb_v[1]));

    hz_ctrl #(.REG_W(RW)) u_dut (
        .dec_vld(dv), .dec_cls(dc), .dec_src1(s1), .dec_src2(s2),
        .ex_vld(ev), .ex_cls(ec), .ex_dst(ed), .mem_vld(mv), .mem_cls(mc), .mem_dst(md),
        .wb_vld(wv), .wb_cls(wc), .wb_dst(wd),
        .hold_front(hold_v[2]), .opa_sel(sa_v[2]), .opb_sel(sb_v[2]));

    // behavioural class tables (R1, R2)
    function automatic bit rd1(int c); return c == 0 || c == 1 || c == 2 || c == 3 || c == 4 || c == 6; endfunction
    function automatic bit rd2(int c); return c == 0 || c == 3 || c == 4; endfunction
    function automatic bit wrt(int c); return c == 0 || c == 1 || c == 2 || c == 5 || c == 6; endfunction

    function automatic bit fwd_ok(int mode, int stg, int c);
        if (mode == 2) return (stg != 0) || (c != 2);
        if (mode == 1) return (stg == 0) && (c == 0 || c == 1);
        return 0;
    endfunction

    task automatic model(input int mode, output bit st, output int a, output int b);
        int vv [3]; int cc [3]; int dd [3];
        vv = '{int'(ev), int'(mv), int'(wv)};
        cc = '{int'(ec), int'(mc), int'(wc)};
        dd = '{int'(ed), int'(md), int'(wd)};
        st = 0; a = 0; b = 0;
        for (int op = 0; op < 2; op++) begin
            int src = (op == 0) ? int'(s1) : int'(s2);
            bit used = dv && ((op == 0) ? rd1(int'(dc)) : rd2(int'(dc)));
            bit found = 0;
            int sel = 0;
            for (int s = 0; s < 3; s++) begin
                if (!found && used && vv[s] != 0 && wrt(cc[s]) && dd[s] != 0 && dd[s] == src) begin
                    found = 1;
                    if (fwd_ok(mode, s, cc[s])) sel = s + 1;
                    else st = 1;
                end
            end
            if (op == 0) a = sel; else b = sel;
        end
    endtask

    task automatic check(input string tag, input int mode, input bit est, input int ea, input int eb);
        checks++;
        if (hold_v[mode] !== est || int'(sa_v[mode]) != ea || int'(sb_v[mode]) != eb) begin
            fails++;
            $display("FAIL %s mode%0d actual hold=%0b a=%0d b=%0d expected hold=%0b a=%0d b=%0d",
                     tag, mode, hold_v[mode], sa_v[mode], sb_v[mode], est, ea, eb);
        end
    endtask

    task automatic check_model(input string tag, input int mode);
        bit st; int a; int b;
        model(mode, st, a, b);
        check(tag, mode, st, a, b);
    endtask

    task automatic idle();
        dv = 0; ev = 0; mv = 0; wv = 0;
        dc = 3'd7; ec = 3'd7; mc = 3'd7; wc = 3'd7;
        s1 = '0; s2 = '0; ed = '0; md = '0; wd = '0;
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic seq_run(input string tag, input int mode, input int prod, input int expn);
        int n = 0;
        step();
        idle();
        dv = 1; dc = 3'd0; s1 = 5'd5; s2 = 5'd6;
        ev = 1; ec = 3'(prod); ed = 5'd5;
        for (int i = 0; i < 8; i++) begin
            #2;
            if (!hold_v[mode]) break;
            n++;
            step();
            wv = mv; wc = mc; wd = md;
            mv = ev; mc = ec; md = ed;
            ev = 0;  ec = 3'd7; ed = '0;
        end
        checks++;
        if (n != expn) begin
            fails++;
            $display("FAIL %s mode%0d producer %0d actual hold cycles=%0d expected=%0d", tag, mode, prod, n, expn);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        checks++; fails++;
        $display("FAIL watchdog R10 actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        idle();
        repeat (3) step();
        #2;
        // reset state: all stages empty (R4)
        for (int m = 0; m < 3; m++) check("R4 reset", m, 0, 0, 0);
        rst_n = 1;

        // R4: decode invalid with a live conflict
        step(); idle(); s1 = 5'd3; ev = 1; ec = 3'd2; ed = 5'd3; dc = 3'd0; #2;
        for (int m = 0; m < 3; m++) check("R4 decode invalid", m, 0, 0, 0);

        // R8: load-use in full mode holds; R7 execute-only also holds
        step(); dv = 1; #2;
        check("R8 load use", 2, 1, 0, 0);
        check("R7 load in ex", 1, 1, 0, 0);
        check("R6 load in ex", 0, 1, 0, 0);

        // R3: destination register 0 never matches
        step(); s1 = '0; ed = '0; ec = 3'd0; #2;
        for (int m = 0; m < 3; m++) check("R3 reg0", m, 0, 0, 0);
        // R3: invalid execute stage
        step(); s1 = 5'd3; ed = 5'd3; ev = 0; #2;
        for (int m = 0; m < 3; m++) check("R3 invalid stage", m, 0, 0, 0);

        // R1: ALU-immediate does not read source 2
        step(); idle(); dv = 1; dc = 3'd1; s1 = 5'd8; s2 = 5'd4; ev = 1; ec = 3'd0; ed = 5'd4; #2;
        for (int m = 0; m < 3; m++) check("R1 aluimm src2 unused", m, 0, 0, 0);
        // R1: jump-and-link reads nothing
        step(); dc = 3'd5; s1 = 5'd4; #2;
        for (int m = 0; m < 3; m++) check("R1 jal no reads", m, 0, 0, 0);

        // R2: store in execute writes nothing
        step(); idle(); dv = 1; dc = 3'd0; s1 = 5'd9; s2 = 5'd9; ev = 1; ec = 3'd3; ed = 5'd9; #2;
        for (int m = 0; m < 3; m++) check("R2 store no write", m, 0, 0, 0);

        // R5: priority, ex beats mem beats wb, operands independent
        step(); ec = 3'd0; ed = 5'd9; mv = 1; mc = 3'd0; md = 5'd9; wv = 1; wc = 3'd0; wd = 5'd10; s2 = 5'd10; #2;
        check("R5 priority", 2, 0, 1, 3);
        check("R7 wb conflict holds", 1, 1, 1, 0);
        check("R6 interlock", 0, 1, 0, 0);
        step(); ev = 0; #2;
        check("R5 mem over wb", 2, 0, 2, 3);

        // R9: youngest stage is a load, older could forward
        step(); ev = 1; ec = 3'd2; ed = 5'd9; #2;
        check("R9 youngest decides", 2, 1, 0, 3);

        // R8: jump-and-link in execute forwards in full mode, holds in execute-only
        step(); idle(); dv = 1; dc = 3'd6; s1 = 5'd1; ev = 1; ec = 3'd5; ed = 5'd1; #2;
        check("R8 jal fwd", 2, 0, 1, 0);
        check("R7 jal holds", 1, 1, 0, 0);

        // R10: hold durations
        seq_run("R10", 0, 0, 3);
        seq_run("R10", 1, 2, 3);
        seq_run("R10", 1, 5, 3);
        seq_run("R10", 1, 0, 0);
        seq_run("R10", 2, 2, 1);
        seq_run("R10", 2, 0, 0);
        seq_run("R10", 2, 5, 0);

        // random comparison against behavioural model (R1 R2 R5 R6 R7 R8 R9)
        for (int i = 0; i < 3000; i++) begin
            step();
            dv = 1'($urandom_range(0, 3) != 0);
            ev = 1'($urandom_range(0, 1)); mv = 1'($urandom_range(0, 1)); wv = 1'($urandom_range(0, 1));
            dc = 3'($urandom_range(0, 7)); ec = 3'($urandom_range(0, 7));
            mc = 3'($urandom_range(0, 7)); wc = 3'($urandom_range(0, 7));
            s1 = 5'($urandom_range(0, 3)); s2 = 5'($urandom_range(0, 3));
            ed = 5'($urandom_range(0, 3)); md = 5'($urandom_range(0, 3)); wd = 5'($urandom_range(0, 3));
            #2;
            check_model("R9 random", 0);
            check_model("R7 random", 1);
            check_model("R8 random", 2);
        end

        finish_run();
    end

endmodule